// File: doc/BRIEF.md
# Snoop Request Responder Queue

This block sits on the processor side of a shared, snooped cluster bus. Other agents put coherency requests on the bus. A read that wants exclusive ownership arrives here as an intervention-exclusive request. An ownership upgrade arrives here as an invalidate request. Each accepted request waits in a small in-order queue. The block then looks it up in a local direct-mapped tag/state array and answers with exactly one coherency state response.

If the line is held dirty-exclusive, the block also raises a data-supply request. That request stays up until the bus grants it, and the block marks completion with a single-cycle pulse. Any request that hits a valid line leaves that line Invalid. A fill port installs line tags and states in the array; it stands in for the rest of the cache.

Top module: `snoop_responder`

## Requirements
- R1: Accepted requests are answered strictly in acceptance order; `rsp_addr` carries the line address of the request being answered.
- R2: Every accepted request yields exactly one `rsp_valid` cycle, and no response is produced without an accepted request.
- R3: `rsp_state` gives the state the line held at lookup: 2'b00 Invalid, 2'b01 Shared, 2'b10 DirtyExclusive. `rsp_op` echoes the request kind: 0 intervention-exclusive, 1 invalidate.
- R4: A response of DirtyExclusive is accompanied, in the same cycle, by `dreq_valid` high with `dreq_addr` equal to the request's line address.
- R5: Both request kinds leave a hit line Invalid, so a later request to the same line is answered Invalid.
- R6: A lookup whose index holds an Invalid line, or a line with a different tag, is answered Invalid and raises no data request.
- R7: The queue holds 4 requests. `req_ready` is low while 4 are held, and a request offered while `req_ready` is low is not accepted and never answered.
- R8: `dreq_valid` and `dreq_addr` hold until a clock edge with `dgrant` high. After that edge `dreq_valid` is low and `ddone` is high for exactly one cycle.
- R9: While a data request is pending, no further response is issued. With an idle block and an empty queue, the response appears after the second rising edge following acceptance.
- R10: After reset the queue is empty, `req_ready` is high, `rsp_valid`, `dreq_valid` and `ddone` are low, and every line is Invalid.
- R11: A `fill_valid` cycle writes the tag and state of `fill_addr` into its index (the low log2(SETS) address bits), replacing whatever line was there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Snoop request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_op | input | 1 | 0 intervention-exclusive, 1 invalidate |
| req_addr | input | ADDR_W | Line address of the snoop |
| rsp_valid | output | 1 | State response valid (one cycle) |
| rsp_state | output | 2 | Line state found at lookup |
| rsp_op | output | 1 | Kind of the answered request |
| rsp_addr | output | ADDR_W | Line address being answered |
| dreq_valid | output | 1 | Data-supply request pending |
| dreq_addr | output | ADDR_W | Line the data request supplies |
| dgrant | input | 1 | Bus grant for the data request |
| ddone | output | 1 | Data supply completed (one cycle) |
| fill_valid | input | 1 | Install a line in the array |
| fill_addr | input | ADDR_W | Line address being installed |
| fill_state | input | 2 | State to install (encoding as R3) |

## Verification
The bench stalls the grant while a dirty-exclusive request is pending and pushes requests until the queue is full. A design with an off-by-one depth would then accept a fifth request or drop one, and an extra or missing response shows up as an unexpected or leftover scoreboard entry. A design that tests only the state and not the tag is caught by snoops to a different tag at an occupied index, which it would answer with a stale state. Repeated snoops to the same line catch a design that forgets to invalidate after a hit. Random bursts with random grant delay check ordering, and catch a design that lets a response slip out while a data request is still unserved.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_DEX = 2'b10
  } line_state_t;

  typedef enum logic {
    OP_INTX  = 1'b0,
    OP_INVAL = 1'b1
  } snoop_op_t;

  typedef enum logic {
    EN_IDLE = 1'b0,
    EN_WAIT = 1'b1
  } engine_st_t;

  // state reported for a lookup
  function automatic line_state_t resp_of(input logic hit, input line_state_t st);
    return hit ? st : LS_INV;
  endfunction

  // a dirty-exclusive owner must supply the block
  function automatic logic needs_data(input line_state_t st);
    return st == LS_DEX;
  endfunction
endpackage

// File: rtl/snp_fifo.sv
module snp_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/snp_tag_array.sv
module snp_tag_array
  import snp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output line_state_t       rd_state,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  line_state_t       fill_state
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_state_t      st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  function automatic logic [IDX_W-1:0] idx_f(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_f(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  assign rd_state = st_q[idx_f(rd_addr)];
  assign rd_hit   = (rd_state != LS_INV) && (tag_q[idx_f(rd_addr)] == tag_f(rd_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LS_INV;
    end else begin
      if (inv_en)  st_q[idx_f(inv_addr)]  <= LS_INV;
      if (fill_en) st_q[idx_f(fill_addr)] <= fill_state;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx_f(fill_addr)] <= tag_f(fill_addr);
  end
endmodule

// File: rtl/snp_engine.sv
module snp_engine
  import snp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  snoop_op_t         q_op,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_pop,
  input  logic              look_hit,
  input  line_state_t       look_state,
  output logic              inv_en,
  output logic              rsp_valid,
  output line_state_t       rsp_state,
  output snoop_op_t         rsp_op,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              dreq_valid,
  output logic [ADDR_W-1:0] dreq_addr,
  input  logic              dgrant,
  output logic              ddone
);
  engine_st_t  fsm_q;
  line_state_t found;
  logic        take;

  assign take   = (fsm_q == EN_IDLE) && !q_empty;
  assign q_pop  = take;
  assign found  = resp_of(look_hit, look_state);
  assign inv_en = take && look_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= EN_IDLE;
      rsp_valid  <= 1'b0;
      rsp_state  <= LS_INV;
      rsp_op     <= OP_INTX;
      rsp_addr   <= '0;
      dreq_valid <= 1'b0;
      dreq_addr  <= '0;
      ddone      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      ddone     <= 1'b0;
      case (fsm_q)
        EN_IDLE: if (take) begin
          rsp_valid <= 1'b1;
          rsp_state <= found;
          rsp_op    <= q_op;
          rsp_addr  <= q_addr;
          if (needs_data(found)) begin
            fsm_q      <= EN_WAIT;
            dreq_valid <= 1'b1;
            dreq_addr  <= q_addr;
          end
        end
        EN_WAIT: if (dgrant) begin
          fsm_q      <= EN_IDLE;
          dreq_valid <= 1'b0;
          ddone      <= 1'b1;
        end
        default: fsm_q <= EN_IDLE;
      endcase
    end
  end

  p_dex_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state == LS_DEX) |-> (dreq_valid && dreq_addr == rsp_addr));
  p_miss_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state != LS_DEX) |-> !dreq_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dgrant) |=> (dreq_valid && $stable(dreq_addr)));
  p_done_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ddone |-> $past(dreq_valid && dgrant));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ddone |=> !ddone);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dgrant) |=> !rsp_valid);
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SETS   = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_state,
  output logic              rsp_op,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              dreq_valid,
  output logic [ADDR_W-1:0] dreq_addr,
  input  logic              dgrant,
  output logic              ddone,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state
);
  localparam int ENTRY_W = ADDR_W + 1;

  logic [ENTRY_W-1:0] head;
  logic               q_empty, q_full, q_pop, q_push;
  logic               look_hit, inv_en;
  line_state_t        look_state, eng_state;
  snoop_op_t          eng_op;
  logic [ADDR_W-1:0]  head_addr;

  assign q_push    = req_valid && req_ready;
  assign req_ready = !q_full;
  assign head_addr = head[ADDR_W-1:0];

  snp_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .din({req_op, req_addr}),
    .pop(q_pop), .dout(head),
    .empty(q_empty), .full(q_full)
  );

  snp_tag_array #(.ADDR_W(ADDR_W), .SETS(SETS)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(head_addr), .rd_hit(look_hit), .rd_state(look_state),
    .inv_en(inv_en), .inv_addr(head_addr),
    .fill_en(fill_valid), .fill_addr(fill_addr),
    .fill_state(line_state_t'(fill_state))
  );

  snp_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .q_empty(q_empty), .q_op(snoop_op_t'(head[ADDR_W])), .q_addr(head_addr),
    .q_pop(q_pop),
    .look_hit(look_hit), .look_state(look_state), .inv_en(inv_en),
    .rsp_valid(rsp_valid), .rsp_state(eng_state), .rsp_op(eng_op),
    .rsp_addr(rsp_addr),
    .dreq_valid(dreq_valid), .dreq_addr(dreq_addr),
    .dgrant(dgrant), .ddone(ddone)
  );

  assign rsp_state = eng_state;
  assign rsp_op    = eng_op;

  p_one_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(q_pop));
endmodule

// File: tb/sim_snoop_responder.sv
`timescale 1ns/1ps
module sim_snoop_responder;
  localparam int AW = 10;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_op, dreq_valid, ddone;
  logic [1:0] rsp_state;
  logic [AW-1:0] rsp_addr, dreq_addr;
  logic dgrant = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [1:0] fill_state = 2'b00;

  always #2 clk = ~clk;

  snoop_responder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_state(rsp_state), .rsp_op(rsp_op), .rsp_addr(rsp_addr),
    .dreq_valid(dreq_valid), .dreq_addr(dreq_addr), .dgrant(dgrant),
    .ddone(ddone), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_state(fill_state)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [1:0]    st;
    logic          op;
  } exp_t;

  exp_t exp_q[$];
  logic [1:0] mst [NS];
  int         mtag [NS];
  int  checks = 0, errors = 0;
  bit  started = 0, done = 0, grant_en = 1;
  int  gwait = 0;

  function automatic int b_idx(input int a); return a % NS; endfunction
  function automatic int b_tag(input int a); return a / NS; endfunction
  function automatic logic [1:0] b_expect(input int a);
    if (mst[b_idx(a)] != 2'b00 && mtag[b_idx(a)] == b_tag(a)) return mst[b_idx(a)];
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic send(input bit op, input int a, output bit acc);
    exp_t e;
    req_op = op; req_addr = AW'(a); req_valid = 1'b1;
    acc = req_ready;
    if (acc) begin
      e.addr = AW'(a); e.st = b_expect(a); e.op = op;
      exp_q.push_back(e);
      if (e.st != 2'b00) mst[b_idx(a)] = 2'b00;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input int a, input logic [1:0] s);
    fill_valid = 1'b1; fill_addr = AW'(a); fill_state = s;
    mst[b_idx(a)] = s; mtag[b_idx(a)] = b_tag(a);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      if (exp_q.size() == 0 && !dreq_valid && !dgrant) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // response scoreboard and grant driver
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "response with nothing outstanding", int'(rsp_addr), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_addr == e.addr, "R1", "response order addr", int'(rsp_addr), int'(e.addr));
          chk(rsp_state == e.st, "R3", "response state", int'(rsp_state), int'(e.st));
          chk(rsp_op == e.op, "R3", "response op echo", int'(rsp_op), int'(e.op));
          if (e.st == 2'b10)
            chk(dreq_valid && dreq_addr == e.addr, "R4", "data request on dirty hit",
                int'(dreq_addr), int'(e.addr));
          else
            chk(!dreq_valid, "R6", "no data request", int'(dreq_valid), 0);
        end
      end
      if (dgrant) begin
        chk(ddone && !dreq_valid, "R8", "done after grant", int'({ddone, dreq_valid}), 2);
        dgrant = 1'b0;
      end else begin
        chk(!ddone, "R8", "stray done", int'(ddone), 0);
        if (dreq_valid && grant_en) begin
          if (gwait == 0) begin
            dgrant = 1'b1;
            gwait = int'($urandom % 3);
          end else gwait--;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [1:0] s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) begin mst[i] = 2'b00; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    chk(!rsp_valid && !dreq_valid && !ddone, "R10", "outputs idle after reset",
        int'({rsp_valid, dreq_valid, ddone}), 0);
    started = 1;
    send(1'b0, 9, acc);
    @(negedge clk);
    chk(rsp_valid && rsp_state == 2'b00, "R10", "line invalid after reset",
        int'(rsp_state), 0);
    drain();

    // R9 latency, R11 fill, R5 invalidation after hit
    fill(3, 2'b01);
    send(1'b1, 3, acc);
    chk(!rsp_valid, "R9", "no response one edge after accept", int'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid && rsp_state == 2'b01, "R9", "response two edges after accept",
        int'(rsp_state), 1);
    drain();
    send(1'b0, 3, acc);
    @(negedge clk);
    chk(rsp_valid && rsp_state == 2'b00, "R5", "line invalid after hit", int'(rsp_state), 0);
    drain();

    // R11 replacement and R6 tag mismatch
    fill(5, 2'b10);
    fill(13, 2'b01);
    send(1'b0, 5, acc);
    @(negedge clk);
    chk(rsp_valid && rsp_state == 2'b00 && !dreq_valid, "R6", "tag mismatch is a miss",
        int'(rsp_state), 0);
    send(1'b0, 13, acc);
    @(negedge clk);
    chk(rsp_valid && rsp_state == 2'b01, "R11", "refilled line state", int'(rsp_state), 1);
    drain();

    // R7 full queue with a stalled data request, R8 hold
    grant_en = 0;
    fill(6, 2'b10);
    send(1'b1, 6, acc);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      send(1'b0, 56 + k, acc);
      chk(acc, "R7", "accept while not full", int'(acc), 1);
    end
    chk(!req_ready, "R7", "ready low when four held", int'(req_ready), 0);
    send(1'b0, 60, acc);
    chk(!acc, "R7", "offer while full not accepted", int'(acc), 0);
    repeat (3) @(negedge clk);
    chk(dreq_valid && dreq_addr == AW'(6), "R8", "data request held without grant",
        int'(dreq_addr), 6);
    grant_en = 1;
    drain();
    chk(exp_q.size() == 0, "R2", "all queued answered", exp_q.size(), 0);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      for (int f = 0; f < 3; f++) begin
        s = 2'($urandom % 3);
        fill(int'($urandom % 2) * NS + int'($urandom % NS), s);
      end
      for (int n = 0; n < 4 + int'($urandom % 6); n++) begin
        int a;
        bit op;
        a  = int'($urandom % 2) * NS + int'($urandom % NS);
        op = 1'($urandom % 2);
        acc = 0;
        while (!acc) send(op, a, acc);
        if ($urandom % 2 == 0) @(negedge clk);
      end
      drain();
    end
    chk(exp_q.size() == 0, "R2", "no response missing at end", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule